// File: doc/BRIEF.md
# Bus Wait-State and Ready Sequencer

This block steps a bus cycle through four base phases (T1, T2, T3, T4). Between T3 and T4 it can insert wait phases (TW). The number of inserted waits comes from a programmed wait code. A 2-bit short code covers 0 to 3 waits. A 3-bit extended code adds four longer counts. When the cycle asks for it, an external ready can also stretch the cycle. That ready can come from an asynchronous source, which is synchronised inside the block, or from a synchronous source, which is used as is.

The programmed waits always run to completion before external ready can end or stretch the cycle. Ready is checked once at a fixed sample point. If it is present there, the cycle keeps its programmed length. If it is absent there, the block keeps inserting waits until ready is seen, then adds one more wait before T4. A one-clock done pulse marks T4, and the block then returns to idle.

Top module: `bus_wait_seq`

## Requirements
- R1: After a synchronous reset, `phase` is 0 (idle), and `wait_active` and `done` are 0.
- R2: A `start` seen in idle gives the phases T1, T2, T3 on the next three clocks. The last phase is T4, during which `done` is 1 for exactly one clock, and the next clock is idle. The phase codes are idle=0, T1=1, T2=2, T3=3, TW=4, T4=5.
- R3: With `code_wide`=0, the programmed wait count N is `wait_code[1:0]` (0 to 3), and `wait_code[2]` has no effect.
- R4: With `code_wide`=1, codes 0 to 3 give N = 0 to 3, and codes 4, 5, 6, 7 give N = 5, 7, 9, 15.
- R5: With `rdy_req`=0, the cycle has exactly N waits whatever the ready inputs do.
- R6: With `rdy_req`=1 and ready present at the sample point, the cycle has exactly N waits. The sample point is T3 when N=0 and the first wait otherwise.
- R7: With `rdy_req`=1 and ready first seen later, in wait number k (counting from 1), the cycle has max(N, k+1) waits.
- R8: `srdy` acts in the same cycle it is presented. `ardy` passes through two flops, so a level first seen in wait k acts as if seen in wait k+2. Either source alone is enough.
- R9: `wait_active` is 1 exactly in the cycles where `phase` is TW.
- R10: A `start` given while a cycle is in progress is ignored: it neither changes that cycle's length nor begins another cycle.
- R11: The wait count and ready mode are captured when the cycle starts. Changing `wait_code`, `code_wide` or `rdy_req` during the cycle does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a bus cycle when idle |
| wait_code | input | 3 | Programmed wait code |
| code_wide | input | 1 | 1 selects the 3-bit extended mapping |
| rdy_req | input | 1 | 1 makes external ready take part |
| ardy | input | 1 | Asynchronous ready, synchronised inside |
| srdy | input | 1 | Synchronous ready |
| phase | output | 3 | Current bus phase code |
| wait_active | output | 1 | High during wait phases |
| done | output | 1 | One-clock pulse in T4 |

## Verification
Every short and extended code is run with ready ignored, which separates the decoding from the ready logic. The `wait_code[2]` bit is flipped in short mode to show that it is not used. The ready-required runs present `srdy` at the sample point, one wait late, and several waits late. This separates "programmed length kept" from "one extra wait after late ready" for zero, small and large N. The `ardy` runs, one with ready held and one with ready raised late, expose the two-clock synchroniser lag. Runs that poke `start` and change the code in mid-cycle show that the cycle parameters are latched and that a busy cycle cannot be restarted.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } bus_phase_e;

  localparam int unsigned NWAIT_W = 4;

  // Turn a wait code into a wait count; long codes use 5 + 2*c, top code 15
  function automatic logic [NWAIT_W-1:0] wait_count(input logic [2:0] code,
                                                     input logic wide);
    logic [NWAIT_W-1:0] n;
    if (!wide || !code[2]) begin
      n = {2'b00, code[1:0]};
    end else if (code[1:0] == 2'b11) begin
      n = 4'd15;
    end else begin
      n = 4'd5 + {1'b0, code[1:0], 1'b0};
    end
    return n;
  endfunction

endpackage

// File: rtl/ready_sync.sv
module ready_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;
  logic [1:0]        warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      warm  <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign sync_out = chain[STAGES-1];

  // R8
  sync_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/wait_decode.sv
module wait_decode
  import bus_wait_pkg::*;
(
  input  logic [2:0]         code,
  input  logic               wide,
  output logic [NWAIT_W-1:0] nwait
);
  always_comb nwait = wait_count(code, wide);

  // R4
  always_comb begin
    wide_range_chk: assert (nwait <= 4'd3 || nwait == 4'd5 || nwait == 4'd7 ||
                            nwait == 4'd9 || nwait == 4'd15);
  end

  // R3
  always_comb begin
    short_range_chk: assert (wide || nwait <= 4'd3);
  end

endmodule

// File: rtl/wait_fsm.sv
module wait_fsm
  import bus_wait_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NWAIT_W-1:0] nwait_in,
  input  logic               req_in,
  input  logic               rdy,
  output logic [2:0]         phase,
  output logic               wait_active,
  output logic               done
);
  localparam logic [CNT_W-1:0] KMAX = {CNT_W{1'b1}};

  bus_phase_e         ph_q, ph_d;
  logic [NWAIT_W-1:0] n_q, n_d;
  logic               req_q, req_d;
  logic               pend_q, pend_d;
  logic [CNT_W-1:0]   k_q, k_d;
  logic [CNT_W-1:0]   tgt_q, tgt_d;
  logic [CNT_W-1:0]   k_inc;
  logic [CNT_W-1:0]   late_tgt;
  logic               wa_q, dn_q;

  always_comb begin
    k_inc = (k_q == KMAX) ? KMAX : k_q + 1'b1;
    // later ready: at least one more wait, never fewer than programmed
    late_tgt = ({{(CNT_W-NWAIT_W){1'b0}}, n_q} > k_inc) ?
               {{(CNT_W-NWAIT_W){1'b0}}, n_q} : k_inc;
  end

  always_comb begin
    ph_d   = ph_q;
    n_d    = n_q;
    req_d  = req_q;
    pend_d = pend_q;
    k_d    = k_q;
    tgt_d  = tgt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_T1;
          n_d   = nwait_in;
          req_d = req_in;
        end
      end
      PH_T1: ph_d = PH_T2;
      PH_T2: ph_d = PH_T3;
      PH_T3: begin
        k_d   = {{(CNT_W-1){1'b0}}, 1'b1};
        tgt_d = {{(CNT_W-NWAIT_W){1'b0}}, n_q};
        if (n_q == '0) begin
          if (!req_q || rdy) begin
            ph_d   = PH_T4;
            pend_d = 1'b0;
          end else begin
            ph_d   = PH_TW;
            pend_d = 1'b1;
          end
        end else begin
          ph_d   = PH_TW;
          pend_d = req_q;
        end
      end
      PH_TW: begin
        if (pend_q) begin
          if (rdy) begin
            pend_d = 1'b0;
            if (k_q == {{(CNT_W-1){1'b0}}, 1'b1} && n_q != '0) begin
              // seen at the sample point: programmed length stands
              if (k_q >= tgt_q) ph_d = PH_T4;
              else k_d = k_inc;
            end else begin
              tgt_d = late_tgt;
              k_d   = k_inc;
            end
          end else begin
            k_d = k_inc;
          end
        end else if (k_q >= tgt_q) begin
          ph_d = PH_T4;
        end else begin
          k_d = k_inc;
        end
      end
      PH_T4:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      n_q    <= '0;
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      k_q    <= '0;
      tgt_q  <= '0;
      wa_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      n_q    <= n_d;
      req_q  <= req_d;
      pend_q <= pend_d;
      k_q    <= k_d;
      tgt_q  <= tgt_d;
      wa_q   <= (ph_d == PH_TW);
      dn_q   <= (ph_d == PH_T4);
    end
  end

  assign phase       = ph_q;
  assign wait_active = wa_q;
  assign done        = dn_q;

  // R2
  t1_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE && start) |=> (ph_q == PH_T1));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && ph_q == PH_IDLE));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && start) |=> (ph_q != PH_T1));

  // R5
  zero_free_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T3 && n_q == '0 && !req_q) |=> (ph_q == PH_T4));

  // R7
  late_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_TW && pend_q && rdy && !(k_q == 1 && n_q != '0)) |=> (ph_q == PH_TW));

endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bus_wait_pkg::*;
#(
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] wait_code,
  input  logic       code_wide,
  input  logic       rdy_req,
  input  logic       ardy,
  input  logic       srdy,
  output logic [2:0] phase,
  output logic       wait_active,
  output logic       done
);
  logic               ardy_s;
  logic               rdy_any;
  logic [NWAIT_W-1:0] nwait;

  ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ardy),
    .sync_out (ardy_s)
  );

  wait_decode u_dec (
    .code  (wait_code),
    .wide  (code_wide),
    .nwait (nwait)
  );

  assign rdy_any = ardy_s | srdy;

  wait_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .nwait_in    (nwait),
    .req_in      (rdy_req),
    .rdy         (rdy_any),
    .phase       (phase),
    .wait_active (wait_active),
    .done        (done)
  );

endmodule

// File: tb/bus_wait_seq_bench.sv
module bus_wait_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] wait_code = '0;
  logic       code_wide = 1'b0;
  logic       rdy_req = 1'b0;
  logic       ardy = 1'b0;
  logic       srdy = 1'b0;
  logic [2:0] phase;
  logic       wait_active;
  logic       done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // ready scheduling: 0 none, 1 srdy from wait index, 2 ardy from wait index, 3 ardy held
  int rmode = 0;
  int rat = 0;
  int widx = 0;

  int exp_q[$];
  int exp_tag[$];
  int ncyc = 0;
  bit seq_bad = 1'b0;
  bit wa_bad = 1'b0;
  bit chk_idle = 1'b0;
  int ndone = 0;

  always #10 clk = ~clk;

  bus_wait_seq u_bus_wait_seq (
    .clk(clk), .rst(rst), .start(start), .wait_code(wait_code),
    .code_wide(code_wide), .rdy_req(rdy_req), .ardy(ardy), .srdy(srdy),
    .phase(phase), .wait_active(wait_active), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int model_n(input int code, input bit wide);
    if (!wide || code < 4) return code % 4;
    case (code)
      4: return 5;
      5: return 7;
      6: return 9;
      default: return 15;
    endcase
  endfunction

  // first wait index at which the design sees ready (0 = T3)
  function automatic int model_waits(input int n, input bit req, input int seen);
    int s;
    int f;
    if (!req) return n;
    s = (n == 0) ? 0 : 1;
    f = (seen > s) ? seen : s;
    if (f == s) return n;
    return (n > f + 1) ? n : f + 1;
  endfunction

  // reactive ready driver and monitor
  always @(negedge clk) begin
    cyc++;
    if (phase == 3'd3) widx = 0;
    else if (phase == 3'd4) widx++;
    srdy = (rmode == 1) && (phase == 3'd3 || phase == 3'd4) && (widx >= rat);
    if (rmode == 2) ardy = (phase == 3'd3 || phase == 3'd4) && (widx >= rat);
    else ardy = (rmode == 3);
    if (!rst) begin
      if (chk_idle) begin
        chk_idle = 1'b0;
        // R2 idle after the done clock
        check(phase == 3'd0 && !done, "R2 idle after T4", int'(phase), 0);
      end
      if (phase != 3'd0) begin
        ncyc++;
        if (ncyc == 1 && phase != 3'd1) seq_bad = 1'b1;
        if (ncyc == 2 && phase != 3'd2) seq_bad = 1'b1;
        if (ncyc == 3 && phase != 3'd3) seq_bad = 1'b1;
        if (done && phase != 3'd5) seq_bad = 1'b1;
      end
      if (wait_active != (phase == 3'd4)) wa_bad = 1'b1;
      if (done) begin
        int e;
        int t;
        ndone++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected done", ncyc - 4, -1);
        end else begin
          e = exp_q.pop_front();
          t = exp_tag.pop_front();
          check(ncyc - 4 == e, $sformatf("R%0d wait count", t), ncyc - 4, e);
          check(!seq_bad, "R2 phase order", int'(seq_bad), 0);
          check(!wa_bad, "R9 wait_active", int'(wa_bad), 0);
        end
        ncyc = 0;
        seq_bad = 1'b0;
        wa_bad = 1'b0;
        chk_idle = 1'b1;
      end
    end
  end

  task automatic run(input int code, input bit wide, input bit req, input int mode,
                     input int at, input int tag, input bit poke);
    int n;
    int seen;
    int d0;
    n = model_n(code, wide);
    seen = (mode == 1) ? at : (mode == 2) ? at + 2 : 0;
    if (mode == 0) seen = 0;
    @(negedge clk);
    wait_code = code[2:0];
    code_wide = wide;
    rdy_req = req;
    rmode = mode;
    rat = at;
    exp_q.push_back(model_waits(n, req, seen));
    exp_tag.push_back(tag);
    d0 = ndone;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10 / R11: disturb inputs mid-cycle
      @(negedge clk);
      start = 1'b1;
      wait_code = 3'd7;
      code_wide = 1'b1;
      rdy_req = ~req;
      @(negedge clk);
      start = 1'b0;
    end
    while (ndone == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    rmode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(phase == 3'd0, "R1 reset phase", int'(phase), 0);
    check(!wait_active && !done, "R1 reset flags", int'({wait_active, done}), 0);

    // R3 short codes, bit 2 ignored
    for (int c = 0; c < 8; c++) run(c, 1'b0, 1'b0, 0, 0, 3, 1'b0);
    // R4 extended codes
    for (int c = 0; c < 8; c++) run(c, 1'b1, 1'b0, 0, 0, 4, 1'b0);
    // R5 ready present but not required, and absent with not required
    run(2, 1'b0, 1'b0, 1, 50, 5, 1'b0);
    run(6, 1'b1, 1'b0, 3, 0, 5, 1'b0);
    // R6 ready at sample point
    run(0, 1'b0, 1'b1, 1, 0, 6, 1'b0);
    run(2, 1'b0, 1'b1, 1, 1, 6, 1'b0);
    run(5, 1'b1, 1'b1, 1, 0, 6, 1'b0);
    // R7 late ready
    run(2, 1'b0, 1'b1, 1, 2, 7, 1'b0);
    run(0, 1'b0, 1'b1, 1, 3, 7, 1'b0);
    run(1, 1'b0, 1'b1, 1, 4, 7, 1'b0);
    run(6, 1'b1, 1'b1, 1, 3, 7, 1'b0);
    run(3, 1'b0, 1'b1, 1, 6, 7, 1'b0);
    // R8 async ready: held, and raised late (two-clock lag)
    run(2, 1'b0, 1'b1, 3, 0, 8, 1'b0);
    run(2, 1'b0, 1'b1, 2, 1, 8, 1'b0);
    run(0, 1'b0, 1'b1, 2, 0, 8, 1'b0);
    // R10 R11 start and settings disturbed while busy
    run(1, 1'b0, 1'b0, 0, 0, 10, 1'b1);
    run(4, 1'b1, 1'b1, 1, 1, 11, 1'b1);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R10 pending items", exp_q.size(), 0);
    check(phase == 3'd0, "R10 idle at end", int'(phase), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cyc < 100000) @(negedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule